// File: doc/BRIEF.md
# Software Interrupt Acceptance Filter

This block screens software-generated interrupt requests aimed at the sixteen lowest interrupt numbers of one processor's interrupt controller. Every request names an interrupt, the group the sender asked for, and whether it was issued from the non-secure world. The filter reads three pieces of configuration:

- the per-interrupt group bit and group-modifier bit, which together give the configured group;
- a control word holding a two-bit non-secure access grade for each interrupt;
- a global bit that turns security off.

From these it either emits a one-cycle set-pending strobe on the line of that interrupt or discards the request. The pending store that consumes the strobe is a separate block, and so is the logic that raises the requests.

The decision is held in a verdict register. It is loaded on every clock edge with one of five named values:

- `V_IDLE`: no request.
- `V_ACCEPT`: the request passes.
- `V_DROP_CODE`: the group code is reserved.
- `V_DROP_GROUP`: the group does not match.
- `V_DROP_GRADE`: the access grade is too low.

Any value can follow any other, because the register takes the verdict for the request presented in the cycle before. Only `V_ACCEPT` drives the output. The filter accepts a new request in every cycle, and the strobe follows its request by exactly one cycle.

Top module: `sgi_accept_filter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `set_pend_vec` is all zeros.
- R2: The configured group of interrupt n is decoded from `cfg_group[n]` and `cfg_grpmod[n]`:
  - group bit 1 gives non-secure group 1, whatever the modifier;
  - group bit 0 with modifier 0 gives group 0;
  - group bit 0 with modifier 1 gives secure group 1.
- R3: `req_grp` is encoded as 2'b00 group 0, 2'b01 secure group 1, 2'b10 non-secure group 1. The code 2'b11 is reserved, and a request carrying it is always dropped.
- R4: A secure group 1 request for an interrupt configured as group 0 is handled as a group 0 request. This adjustment happens before any other check.
- R5: After the R4 adjustment, a request whose group differs from the configured group is dropped.
- R6: The non-secure access grade of interrupt n is `cfg_nsacc[2n+1:2n]`. Only the grade of the addressed interrupt affects the decision.
- R7: When `sec_disable` is 0 and `req_ns` is 1, the request is dropped if the grade is too low:
  - a group 0 interrupt needs a grade of at least 1;
  - a group 1 interrupt (secure or non-secure) needs a grade of at least 2.
- R8: When `req_ns` is 0 or `sec_disable` is 1, the access grade plays no part in the decision.
- R9: An accepted request raises only bit `req_id` of `set_pend_vec`, for one cycle, in the cycle after the clock edge that sampled it. Back-to-back requests each produce their own strobe.
- R10: A cycle with `req_valid` low, or a dropped request, leaves `set_pend_vec` all zeros in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_id | input | 4 | Interrupt number of the request |
| req_grp | input | 2 | Requested group code (R3) |
| req_ns | input | 1 | Request issued from the non-secure world |
| cfg_group | input | 16 | Group bit per interrupt |
| cfg_grpmod | input | 16 | Group-modifier bit per interrupt |
| cfg_nsacc | input | 32 | Two-bit non-secure access grade per interrupt |
| sec_disable | input | 1 | Security disabled when 1 |
| set_pend_vec | output | 16 | One-hot set-pending strobe |

## Verification
The hardest situation to reach is a request that passes or fails on the grade of exactly its own interrupt while every neighbour's group and grade would give the opposite verdict. A wrong field offset or a wrong group index then still yields a plausible answer. To force this, the stimulus sweeps every interrupt number, group code, world flag, security setting, group and modifier pair, and grade. For each combination it loads every other interrupt with the inverted group bits and the complementary grade. Requests are issued back to back, so each strobe is also checked against its neighbour in time.

// File: rtl/sgi_filt_pkg.sv
package sgi_filt_pkg;

    typedef enum logic [1:0] {
        GRP_G0   = 2'b00,
        GRP_G1S  = 2'b01,
        GRP_G1NS = 2'b10,
        GRP_RSVD = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        V_IDLE       = 3'd0,
        V_ACCEPT     = 3'd1,
        V_DROP_CODE  = 3'd2,
        V_DROP_GROUP = 3'd3,
        V_DROP_GRADE = 3'd4
    } verdict_e;

    localparam int unsigned GRADE_G0_MIN = 1;
    localparam int unsigned GRADE_G1_MIN = 2;

endpackage

// File: rtl/sgi_group_resolve.sv
module sgi_group_resolve
    import sgi_filt_pkg::*;
#(
    parameter int NUM_SGI = 16,
    localparam int ID_W = $clog2(NUM_SGI)
) (
    input  logic [NUM_SGI-1:0] cfg_group,
    input  logic [NUM_SGI-1:0] cfg_grpmod,
    input  logic [ID_W-1:0]    sel_id,
    output grp_e               cfg_grp
);

    grp_e per_irq [NUM_SGI];

    generate
        for (genvar g = 0; g < NUM_SGI; g++) begin : g_decode
            always_comb begin
                if (cfg_group[g])
                    per_irq[g] = GRP_G1NS;
                else if (cfg_grpmod[g])
                    per_irq[g] = GRP_G1S;
                else
                    per_irq[g] = GRP_G0;
            end
        end
    endgenerate

    assign cfg_grp = per_irq[sel_id];

    always_comb begin
        assert_never_rsvd_R2: assert (cfg_grp != GRP_RSVD);
    end

endmodule

// File: rtl/sgi_grade_gate.sv
module sgi_grade_gate
    import sgi_filt_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int ACC_W   = 2,
    localparam int ID_W   = $clog2(NUM_SGI),
    localparam int WORD_W = NUM_SGI * ACC_W
) (
    input  logic [WORD_W-1:0] cfg_nsacc,
    input  logic [ID_W-1:0]   sel_id,
    input  grp_e              cfg_grp,
    input  logic              req_ns,
    input  logic              sec_disable,
    output logic              permit,
    output logic [ACC_W-1:0]  grade
);

    logic checked;

    assign grade   = cfg_nsacc[sel_id*ACC_W +: ACC_W];
    assign checked = req_ns && !sec_disable;

    always_comb begin
        if (!checked)
            permit = 1'b1;
        else if (cfg_grp == GRP_G0)
            permit = (int'(grade) >= GRADE_G0_MIN);
        else
            permit = (int'(grade) >= GRADE_G1_MIN);
    end

    always_comb begin
        assert_zero_grade_R7: assert (!(checked && grade == '0 && permit));
    end

endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
    import sgi_filt_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int ACC_W   = 2,
    localparam int ID_W   = $clog2(NUM_SGI),
    localparam int WORD_W = NUM_SGI * ACC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ID_W-1:0]    req_id,
    input  logic [1:0]         req_grp,
    input  logic               req_ns,
    input  logic [NUM_SGI-1:0] cfg_group,
    input  logic [NUM_SGI-1:0] cfg_grpmod,
    input  logic [WORD_W-1:0]  cfg_nsacc,
    input  logic               sec_disable,
    output logic [NUM_SGI-1:0] set_pend_vec
);

    grp_e             cfg_grp;
    grp_e             req_code;
    grp_e             eff_grp;
    logic             permit;
    logic [ACC_W-1:0] grade;
    verdict_e         verdict_nxt;
    verdict_e         verdict_q;
    logic [ID_W-1:0]  id_q;

    sgi_group_resolve #(.NUM_SGI(NUM_SGI)) u_resolve (
        .cfg_group  (cfg_group),
        .cfg_grpmod (cfg_grpmod),
        .sel_id     (req_id),
        .cfg_grp    (cfg_grp)
    );

    sgi_grade_gate #(.NUM_SGI(NUM_SGI), .ACC_W(ACC_W)) u_gate (
        .cfg_nsacc   (cfg_nsacc),
        .sel_id      (req_id),
        .cfg_grp     (cfg_grp),
        .req_ns      (req_ns),
        .sec_disable (sec_disable),
        .permit      (permit),
        .grade       (grade)
    );

    assign req_code = grp_e'(req_grp);

    always_comb begin
        if (req_code == GRP_G1S && cfg_grp == GRP_G0)
            eff_grp = GRP_G0;
        else
            eff_grp = req_code;
    end

    always_comb begin
        if (!req_valid)
            verdict_nxt = V_IDLE;
        else if (req_code == GRP_RSVD)
            verdict_nxt = V_DROP_CODE;
        else if (eff_grp != cfg_grp)
            verdict_nxt = V_DROP_GROUP;
        else if (!permit)
            verdict_nxt = V_DROP_GRADE;
        else
            verdict_nxt = V_ACCEPT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= V_IDLE;
            id_q      <= '0;
        end else begin
            verdict_q <= verdict_nxt;
            id_q      <= req_id;
        end
    end

    always_comb begin
        set_pend_vec = '0;
        unique case (verdict_q)
            V_ACCEPT:     set_pend_vec[id_q] = 1'b1;
            V_IDLE,
            V_DROP_CODE,
            V_DROP_GROUP,
            V_DROP_GRADE: set_pend_vec = '0;
            default:      set_pend_vec = '0;
        endcase
    end

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_pend_vec));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (set_pend_vec == '0));

    assert_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_grp == 2'b11) |=> (set_pend_vec == '0));

    assert_grade_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ns && !sec_disable && grade == '0) |=> (set_pend_vec == '0));

    assert_g1ns_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_grp == 2'b00 && cfg_group[req_id]) |=> (set_pend_vec == '0));

    assert_strobe_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eff_grp == cfg_grp && req_code != GRP_RSVD && permit)
            |=> (set_pend_vec[$past(req_id)] == 1'b1));

endmodule

// File: tb/tb_sgi_accept_filter.sv
`timescale 1ns/1ps
module tb_sgi_accept_filter;

    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [3:0]    req_id;
    logic [1:0]    req_grp;
    logic          req_ns;
    logic [N-1:0]  cfg_group;
    logic [N-1:0]  cfg_grpmod;
    logic [2*N-1:0] cfg_nsacc;
    logic          sec_disable;
    logic [N-1:0]  set_pend_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sgi_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_grp(req_grp), .req_ns(req_ns), .cfg_group(cfg_group),
        .cfg_grpmod(cfg_grpmod), .cfg_nsacc(cfg_nsacc),
        .sec_disable(sec_disable), .set_pend_vec(set_pend_vec)
    );

    task automatic check(input logic [N-1:0] exp, input string tag);
        n_cmp++;
        if (set_pend_vec !== exp) begin
            n_bad++;
            $display("FAIL %s: set_pend_vec actual %h expected %h", tag, set_pend_vec, exp);
        end
    endtask

    // configured group: 0=G0, 1=G1S, 2=G1NS (R2)
    function automatic int cfg_of(input bit g, input bit m);
        if (g) return 2;
        return m ? 1 : 0;
    endfunction

    initial begin
        logic [N-1:0] exp_prev;
        string        tag_prev;
        bit           have_prev;
        rst_n = 1'b0; req_valid = 1'b1; req_id = 4'd3; req_grp = 2'b00;
        req_ns = 1'b0; cfg_group = '0; cfg_grpmod = '0; cfg_nsacc = '1;
        sec_disable = 1'b0;
        repeat (3) @(negedge clk);
        check('0, "R1 during reset");
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check('0, "R1 after release");

        // R10: idle cycles with arbitrary fields
        req_id = 4'd7; req_grp = 2'b00;
        @(negedge clk);
        check('0, "R10 idle");

        have_prev = 0; exp_prev = '0; tag_prev = "";
        for (int sd = 0; sd < 2; sd++)
        for (int g = 0; g < 2; g++)
        for (int m = 0; m < 2; m++)
        for (int f = 0; f < 4; f++)
        for (int ns = 0; ns < 2; ns++)
        for (int rg = 0; rg < 4; rg++)
        for (int id = 0; id < N; id++) begin
            int cfg, eff, need;
            bit ok;
            string tag;
            if (have_prev) check(exp_prev, tag_prev);
            // target interrupt gets (g,m,f); all others the opposite (R6)
            for (int k = 0; k < N; k++) begin
                cfg_group[k]  = (k == id) ? g[0] : ~g[0];
                cfg_grpmod[k] = (k == id) ? m[0] : ~m[0];
                cfg_nsacc[2*k +: 2] = (k == id) ? 2'(f) : 2'(3 - f);
            end
            sec_disable = sd[0]; req_ns = ns[0]; req_grp = 2'(rg);
            req_id = 4'(id); req_valid = 1'b1;
            cfg = cfg_of(g[0], m[0]);
            eff = (rg == 1 && cfg == 0) ? 0 : rg;
            ok = 1;
            if (rg == 3) begin ok = 0; tag = "R3 reserved code"; end
            else if (eff != cfg) begin ok = 0; tag = "R5 R2 group mismatch"; end
            else if (ns == 1 && sd == 0) begin
                need = (cfg == 0) ? 1 : 2;
                if (f < need) ok = 0;
                tag = "R7 R6 grade check";
            end else tag = "R8 no grade check";
            if (ok && rg == 1 && cfg == 0) tag = "R4 downgrade";
            if (ok && tag == "R8 no grade check") tag = "R8 R9 accepted";
            exp_prev = ok ? (N'(1) << id) : '0;
            tag_prev = tag;
            have_prev = 1;
            @(negedge clk);
        end
        check(exp_prev, tag_prev);
        req_valid = 1'b0;
        @(negedge clk);
        check('0, "R9 single cycle strobe");
        @(negedge clk);
        check('0, "R10 idle after sweep");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule